// File: doc/BRIEF.md
# Sponge Authenticated-Encryption Phase Sequencer

This block steps a 320-bit sponge state through the phases of an authenticated encryption. A start pulse loads the state from a fixed initial word, a 128-bit key and a 128-bit nonce. The block then asks an external permutation unit for a set number of rounds over a start/done handshake. Along the way it absorbs associated-data blocks, absorbs plaintext blocks while emitting the matching ciphertext, and delivers a 128-bit tag at the end. The key is mixed into the state three times. It goes into the low half of the capacity after setup, into the high half of the capacity before the closing permutation, and into the low half again to form the tag.

The state is kept as five 64-bit words. Word x0 occupies bits 319:256 and word x4 occupies bits 63:0. The 64-bit rate is x0 and the capacity is x1 to x4. The two round counts, one for setup and closing and one for each intermediate block, are captured at start. The permutation itself lies outside the block. The surrounding system supplies one, and the testbench uses a simple stand-in.

Top module: `sponge_aead_seq`

## Requirements
- R1: After reset, busy, ad_ready, pt_ready, ct_valid, tag_valid and perm_start are all 0.
- R2: On start while idle, the state becomes {IV_WORD, key, nonce} with IV_WORD in x0, key in x1:x2 and nonce in x3:x4. This state is presented on perm_state_out while perm_start is high, with perm_rounds equal to rounds_a.
- R3: When the setup permutation completes, the key is XORed into bits 127:0 of its result.
- R4: An associated-data block is taken on a cycle with ad_valid and ad_ready both high. It is XORed into x0, and the next cycle raises perm_start for one cycle with perm_rounds equal to rounds_b.
- R5: Bit 0 of x4 is inverted exactly once before the first plaintext block is absorbed. This happens after the last associated-data permutation, or right after setup when has_ad was 0. When has_ad is 0, ad_ready never rises.
- R6: A block's first byte sits in bits 63:56. On a block flagged last with n bytes (0 to 8), bytes n to 7 of the input are ignored. Byte n is then replaced by 0x80 and the rest by zero, so a full last block gets no pad. Blocks that are not last are taken whole.
- R7: Each plaintext block is XORed into x0, and the updated x0 becomes the ciphertext. ct_valid rises for one cycle, the cycle after acceptance. ct_bytes gives the byte count (8 for a block that is not last), and bytes beyond that count are zero. A plaintext block that is not last is followed by a rounds_b permutation.
- R8: After the last plaintext block, the key is XORed into bits 255:128 and a rounds_a permutation is started.
- R9: The tag equals bits 127:0 of the closing permutation's result XOR the key. tag_valid pulses for one cycle, busy is 0 in that cycle, and the tag stays unchanged afterwards.
- R10: Changes to rounds_a and rounds_b after start have no effect on the current run.
- R11: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| has_ad | input | 1 | Run contains associated data |
| key | input | 128 | Secret key |
| nonce | input | 128 | Public nonce |
| rounds_a | input | RND_W | Rounds for setup and closing |
| rounds_b | input | RND_W | Rounds after each intermediate block |
| ad_valid | input | 1 | Associated-data block offered |
| ad_ready | output | 1 | Associated-data block can be taken |
| ad_data | input | 64 | Associated-data block |
| ad_bytes | input | 4 | Valid bytes of a last block |
| ad_last | input | 1 | Final associated-data block |
| pt_valid | input | 1 | Plaintext block offered |
| pt_ready | output | 1 | Plaintext block can be taken |
| pt_data | input | 64 | Plaintext block |
| pt_bytes | input | 4 | Valid bytes of a last block |
| pt_last | input | 1 | Final plaintext block |
| ct_valid | output | 1 | Ciphertext block present |
| ct_data | output | 64 | Ciphertext block |
| ct_bytes | output | 4 | Ciphertext byte count |
| ct_last | output | 1 | Final ciphertext block |
| tag_valid | output | 1 | Tag ready pulse |
| tag | output | 128 | Authentication tag |
| busy | output | 1 | Run in progress |
| perm_start | output | 1 | Launch permutation |
| perm_rounds | output | RND_W | Round count for permutation |
| perm_state_out | output | 320 | State handed to permutation |
| perm_done | input | 1 | Permutation finished |
| perm_state_in | input | 320 | Permuted state |

## Verification
Two functions share a single clock edge when the last plaintext block is taken. In that cycle the ciphertext is produced and the high-capacity key injection is applied, and both feed the closing launch. A second pairing is the completion of the last associated-data permutation, which occurs together with the domain-separation flip. The bench provokes both by offering the next block before ready rises, so acceptance follows the state change immediately. It judges them against an independent model of the whole run. That model compares every state handed to the stand-in permutation, every round count, every ciphertext block and the tag. Mistimed or misplaced key mixing, padding or flipping therefore shows up as a mismatch.

// File: rtl/sponge_pkg.sv
package sponge_pkg;
    localparam int STATE_W    = 320;
    localparam int WORD_W     = 64;
    localparam int KEY_W      = 128;
    localparam int RATE_W     = WORD_W;
    localparam int RATE_B     = RATE_W / 8;
    localparam int CNT_W      = $clog2(RATE_B + 1);
    localparam int CAP_HI_LSB = STATE_W - RATE_W - KEY_W;

    typedef enum logic [2:0] {
        PH_IDLE, PH_LAUNCH, PH_WAIT, PH_AD, PH_PT
    } phase_t;

    typedef enum logic [2:0] {
        RT_INIT, RT_AD, RT_ADLAST, RT_PT, RT_FINAL
    } ret_t;
endpackage

// File: rtl/sponge_blkpad.sv
module sponge_blkpad #(
    parameter int W  = 64,
    parameter int CW = 4
) (
    input  logic [W-1:0]  data_i,
    input  logic [CW-1:0] nbytes_i,
    input  logic          last_i,
    output logic [W-1:0]  blk_o,
    output logic [W-1:0]  mask_o
);
    localparam int NB = W / 8;

    for (genvar j = 0; j < NB; j++) begin : g_byte
        localparam int LSB = W - 8 * (j + 1);
        logic keep, padb;
        assign keep = !last_i || (CW'(j) < nbytes_i);
        assign padb = last_i && (nbytes_i == CW'(j));
        assign blk_o[LSB +: 8]  = keep ? data_i[LSB +: 8] : (padb ? 8'h80 : 8'h00);
        assign mask_o[LSB +: 8] = keep ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/sponge_keyxor.sv
module sponge_keyxor #(
    parameter int SW  = 320,
    parameter int KW  = 128,
    parameter int LSB = 0
) (
    input  logic [SW-1:0] state_i,
    input  logic [KW-1:0] key_i,
    output logic [SW-1:0] state_o
);
    always_comb begin
        state_o = state_i;
        state_o[LSB +: KW] = state_i[LSB +: KW] ^ key_i;
    end
endmodule

// File: rtl/sponge_aead_seq.sv
module sponge_aead_seq
    import sponge_pkg::*;
#(
    parameter int               RND_W   = 4,
    parameter logic [WORD_W-1:0] IV_WORD = 64'hC3A5_0C06_4000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                has_ad,
    input  logic [KEY_W-1:0]    key,
    input  logic [KEY_W-1:0]    nonce,
    input  logic [RND_W-1:0]    rounds_a,
    input  logic [RND_W-1:0]    rounds_b,
    input  logic                ad_valid,
    output logic                ad_ready,
    input  logic [RATE_W-1:0]   ad_data,
    input  logic [CNT_W-1:0]    ad_bytes,
    input  logic                ad_last,
    input  logic                pt_valid,
    output logic                pt_ready,
    input  logic [RATE_W-1:0]   pt_data,
    input  logic [CNT_W-1:0]    pt_bytes,
    input  logic                pt_last,
    output logic                ct_valid,
    output logic [RATE_W-1:0]   ct_data,
    output logic [CNT_W-1:0]    ct_bytes,
    output logic                ct_last,
    output logic                tag_valid,
    output logic [KEY_W-1:0]    tag,
    output logic                busy,
    output logic                perm_start,
    output logic [RND_W-1:0]    perm_rounds,
    output logic [STATE_W-1:0]  perm_state_out,
    input  logic                perm_done,
    input  logic [STATE_W-1:0]  perm_state_in
);
    typedef struct packed {
        phase_t               ph;
        ret_t                 ret;
        logic [STATE_W-1:0]   st;
        logic [KEY_W-1:0]     key;
        logic [RND_W-1:0]     rnd_a;
        logic [RND_W-1:0]     rnd_b;
        logic [RND_W-1:0]     rnd;
        logic                 has_ad;
        logic                 ct_valid;
        logic [RATE_W-1:0]    ct_data;
        logic [CNT_W-1:0]     ct_bytes;
        logic                 ct_last;
        logic                 tag_valid;
        logic [KEY_W-1:0]     tag;
    } regs_t;

    regs_t r_d, r_q;

    logic [RATE_W-1:0]  ad_blk, ad_msk, pt_blk, pt_msk, pt_rate;
    logic [STATE_W-1:0] pt_abs, init_mix, fin_mix;

    sponge_blkpad #(.W(RATE_W), .CW(CNT_W)) u_ad_pad (
        .data_i(ad_data), .nbytes_i(ad_bytes), .last_i(ad_last),
        .blk_o(ad_blk), .mask_o(ad_msk)
    );

    sponge_blkpad #(.W(RATE_W), .CW(CNT_W)) u_pt_pad (
        .data_i(pt_data), .nbytes_i(pt_bytes), .last_i(pt_last),
        .blk_o(pt_blk), .mask_o(pt_msk)
    );

    // Low half of capacity: after setup
    sponge_keyxor #(.SW(STATE_W), .KW(KEY_W), .LSB(0)) u_kx_lo (
        .state_i(perm_state_in), .key_i(r_q.key), .state_o(init_mix)
    );

    // High half of capacity: before closing permutation
    sponge_keyxor #(.SW(STATE_W), .KW(KEY_W), .LSB(CAP_HI_LSB)) u_kx_hi (
        .state_i(pt_abs), .key_i(r_q.key), .state_o(fin_mix)
    );

    assign pt_rate = r_q.st[STATE_W-1 -: RATE_W] ^ pt_blk;
    assign pt_abs  = {pt_rate, r_q.st[STATE_W-RATE_W-1:0]};

    always_comb begin
        r_d           = r_q;
        r_d.ct_valid  = 1'b0;
        r_d.tag_valid = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.st     = {IV_WORD, key, nonce};
                    r_d.key    = key;
                    r_d.rnd_a  = rounds_a;
                    r_d.rnd_b  = rounds_b;
                    r_d.rnd    = rounds_a;
                    r_d.has_ad = has_ad;
                    r_d.ret    = RT_INIT;
                    r_d.ph     = PH_LAUNCH;
                end
            end
            PH_LAUNCH: r_d.ph = PH_WAIT;
            PH_WAIT: begin
                if (perm_done) begin
                    unique case (r_q.ret)
                        RT_INIT: begin
                            r_d.st    = init_mix;
                            r_d.st[0] = init_mix[0] ^ !r_q.has_ad;
                            r_d.ph    = r_q.has_ad ? PH_AD : PH_PT;
                        end
                        RT_AD: begin
                            r_d.st = perm_state_in;
                            r_d.ph = PH_AD;
                        end
                        RT_ADLAST: begin
                            r_d.st    = perm_state_in;
                            r_d.st[0] = ~perm_state_in[0];
                            r_d.ph    = PH_PT;
                        end
                        RT_PT: begin
                            r_d.st = perm_state_in;
                            r_d.ph = PH_PT;
                        end
                        default: begin
                            r_d.tag       = perm_state_in[KEY_W-1:0] ^ r_q.key;
                            r_d.tag_valid = 1'b1;
                            r_d.ph        = PH_IDLE;
                        end
                    endcase
                end
            end
            PH_AD: begin
                if (ad_valid) begin
                    r_d.st[STATE_W-1 -: RATE_W] = r_q.st[STATE_W-1 -: RATE_W] ^ ad_blk;
                    r_d.rnd = r_q.rnd_b;
                    r_d.ret = ad_last ? RT_ADLAST : RT_AD;
                    r_d.ph  = PH_LAUNCH;
                end
            end
            PH_PT: begin
                if (pt_valid) begin
                    r_d.ct_valid = 1'b1;
                    r_d.ct_data  = pt_rate & pt_msk;
                    r_d.ct_bytes = pt_last ? pt_bytes : CNT_W'(RATE_B);
                    r_d.ct_last  = pt_last;
                    r_d.ph       = PH_LAUNCH;
                    if (pt_last) begin
                        r_d.st  = fin_mix;
                        r_d.rnd = r_q.rnd_a;
                        r_d.ret = RT_FINAL;
                    end else begin
                        r_d.st  = pt_abs;
                        r_d.rnd = r_q.rnd_b;
                        r_d.ret = RT_PT;
                    end
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ad_ready       = (r_q.ph == PH_AD);
    assign pt_ready       = (r_q.ph == PH_PT);
    assign busy           = (r_q.ph != PH_IDLE);
    assign perm_start     = (r_q.ph == PH_LAUNCH);
    assign perm_rounds    = r_q.rnd;
    assign perm_state_out = r_q.st;
    assign ct_valid       = r_q.ct_valid;
    assign ct_data        = r_q.ct_data;
    assign ct_bytes       = r_q.ct_bytes;
    assign ct_last        = r_q.ct_last;
    assign tag_valid      = r_q.tag_valid;
    assign tag            = r_q.tag;

    AST_AD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_valid && ad_ready) |=> (perm_start && perm_rounds == $past(r_q.rnd_b))); // R4
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        perm_start |=> !perm_start); // R4
    AST_CT_AFTER_PT: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> $past(pt_valid && pt_ready)); // R7
    AST_FINAL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && pt_ready && pt_last) |=> (perm_start && perm_rounds == $past(r_q.rnd_a))); // R8
    AST_TAG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> ($past(perm_done) && !busy)); // R9
endmodule

// File: tb/tb_sponge_aead_seq.sv
`timescale 1ns/1ps
module tb_sponge_aead_seq;
    localparam logic [63:0] TB_IV = 64'h5A17_0E06_8000_0000;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         start = 0, has_ad = 0;
    logic [127:0] key = '0, nonce = '0;
    logic [3:0]   rounds_a = 0, rounds_b = 0;
    logic         ad_valid = 0, ad_last = 0, pt_valid = 0, pt_last = 0;
    logic [63:0]  ad_data = '0, pt_data = '0;
    logic [3:0]   ad_bytes = 0, pt_bytes = 0;
    logic         ad_ready, pt_ready, ct_valid, ct_last, tag_valid, busy, perm_start;
    logic [63:0]  ct_data;
    logic [3:0]   ct_bytes, perm_rounds;
    logic [127:0] tag;
    logic [319:0] perm_state_out, perm_state_in;
    logic         perm_done = 0;

    always #5 clk = ~clk;

    sponge_aead_seq #(.RND_W(4), .IV_WORD(TB_IV)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .has_ad(has_ad), .key(key), .nonce(nonce),
        .rounds_a(rounds_a), .rounds_b(rounds_b),
        .ad_valid(ad_valid), .ad_ready(ad_ready), .ad_data(ad_data), .ad_bytes(ad_bytes), .ad_last(ad_last),
        .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_data(pt_data), .pt_bytes(pt_bytes), .pt_last(pt_last),
        .ct_valid(ct_valid), .ct_data(ct_data), .ct_bytes(ct_bytes), .ct_last(ct_last),
        .tag_valid(tag_valid), .tag(tag), .busy(busy),
        .perm_start(perm_start), .perm_rounds(perm_rounds), .perm_state_out(perm_state_out),
        .perm_done(perm_done), .perm_state_in(perm_state_in)
    );

    int errors = 0, checks = 0;

    function automatic logic [319:0] f_perm(input logic [319:0] s, input logic [3:0] r);
        logic [319:0] t = s;
        for (int i = 0; i < 16; i++) begin
            if (i < int'(r)) t = {t[316:0], t[319:317]} ^ {256'h0, 64'h9E37_79B9_7F4A_7C15 ^ 64'(i)};
        end
        return t;
    endfunction

    function automatic logic [63:0] f_pad(input logic [63:0] d, input int n, input bit last);
        logic [63:0] o;
        for (int j = 0; j < 8; j++) begin
            if (!last || j < n) o[63-8*j -: 8] = d[63-8*j -: 8];
            else if (j == n)    o[63-8*j -: 8] = 8'h80;
            else                o[63-8*j -: 8] = 8'h00;
        end
        return o;
    endfunction

    function automatic logic [63:0] f_mask(input int n, input bit last);
        logic [63:0] o;
        for (int j = 0; j < 8; j++) o[63-8*j -: 8] = (!last || j < n) ? 8'hFF : 8'h00;
        return o;
    endfunction

    // stand-in permutation with latency and a log of every launch
    logic [319:0] pin = '0;
    logic [3:0]   prnd = 0, pcnt = 0;
    logic         pact = 0;
    logic [319:0] cap_in [64];
    logic [3:0]   cap_r  [64];
    int           cap_n = 0;
    assign perm_state_in = f_perm(pin, prnd);

    always @(posedge clk) begin
        perm_done <= 1'b0;
        if (!rst_n) begin
            pact <= 1'b0;
        end else if (perm_start) begin
            pin  <= perm_state_out;
            prnd <= perm_rounds;
            pcnt <= perm_rounds;
            pact <= 1'b1;
            if (cap_n < 64) begin
                cap_in[cap_n] <= perm_state_out;
                cap_r[cap_n]  <= perm_rounds;
                cap_n         <= cap_n + 1;
            end
        end else if (pact) begin
            if (pcnt <= 1) begin
                perm_done <= 1'b1;
                pact      <= 1'b0;
            end else begin
                pcnt <= pcnt - 1;
            end
        end
    end

    logic [63:0] ct_got [64];
    logic [3:0]  ctb_got [64];
    int          ct_n = 0, adr_seen = 0;
    always @(negedge clk) begin
        if (ct_valid && ct_n < 64) begin
            ct_got[ct_n]  = ct_data;
            ctb_got[ct_n] = ct_bytes;
            ct_n++;
        end
        if (ad_ready) adr_seen++;
    end

    // scenario data and reference model
    logic [63:0]  ad_blk [8], pt_blk [8];
    int           n_ad, n_pt, ad_ln, pt_ln;
    logic [3:0]   ra, rb;
    logic [319:0] exp_in [16];
    logic [3:0]   exp_r  [16];
    string        exp_lbl [16];
    int           exp_n;
    logic [63:0]  exp_ct [8];
    int           exp_ctb [8];
    logic [127:0] exp_tag;

    task automatic chk(input bit ok, input string req, input logic [319:0] act, input logic [319:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build_ref();
        logic [319:0] s;
        logic [63:0]  x;
        string        lbl;
        int           n;
        bit           lst;
        exp_n = 0;
        s = {TB_IV, key, nonce};
        exp_in[0] = s; exp_r[0] = ra; exp_lbl[0] = "R2"; exp_n = 1;
        s = f_perm(s, ra);
        s[127:0] ^= key;
        lbl = "R3";
        for (int i = 0; i < n_ad; i++) begin
            lst = (i == n_ad - 1);
            n = lst ? ad_ln : 8;
            s[319:256] ^= f_pad(ad_blk[i], n, lst);
            exp_in[exp_n] = s; exp_r[exp_n] = rb;
            exp_lbl[exp_n] = (lbl == "") ? "R4 R6" : lbl;
            exp_n++; lbl = "";
            s = f_perm(s, rb);
        end
        s[0] = ~s[0];
        lbl = (lbl == "R3") ? "R3 R5" : "R5";
        for (int i = 0; i < n_pt; i++) begin
            lst = (i == n_pt - 1);
            n = lst ? pt_ln : 8;
            x = s[319:256] ^ f_pad(pt_blk[i], n, lst);
            exp_ct[i] = x & f_mask(n, lst);
            exp_ctb[i] = n;
            s[319:256] = x;
            if (!lst) begin
                exp_in[exp_n] = s; exp_r[exp_n] = rb;
                exp_lbl[exp_n] = (lbl == "") ? "R7" : lbl;
                exp_n++; lbl = "";
                s = f_perm(s, rb);
            end else begin
                s[255:128] ^= key;
                exp_in[exp_n] = s; exp_r[exp_n] = ra;
                exp_lbl[exp_n] = (lbl == "") ? "R8" : {lbl, " R8"};
                exp_n++;
                s = f_perm(s, ra);
                exp_tag = s[127:0] ^ key;
            end
        end
    endtask

    task automatic run_case(input string name, input bit noisy);
        int cb, tb0;
        logic [127:0] tag_seen;
        build_ref();
        cb = cap_n; tb0 = ct_n; adr_seen = 0;
        @(negedge clk);
        has_ad = (n_ad > 0); rounds_a = ra; rounds_b = rb; start = 1;
        @(negedge clk);
        start = 0;
        if (noisy) begin
            // R10, R11: new round counts and nonce plus a stray start while busy
            rounds_a = 4'd3; rounds_b = 4'd2; nonce = ~nonce;
            @(negedge clk); start = 1;
            @(negedge clk); start = 0;
        end
        for (int i = 0; i < n_ad; i++) begin
            ad_valid = 1; ad_data = ad_blk[i]; ad_last = (i == n_ad - 1);
            ad_bytes = ad_last ? 4'(ad_ln) : 4'd8;
            while (!ad_ready) @(negedge clk);
            @(negedge clk);
            ad_valid = 0;
        end
        for (int i = 0; i < n_pt; i++) begin
            pt_valid = 1; pt_data = pt_blk[i]; pt_last = (i == n_pt - 1);
            pt_bytes = pt_last ? 4'(pt_ln) : 4'd8;
            while (!pt_ready) @(negedge clk);
            @(negedge clk);
            pt_valid = 0;
        end
        while (!tag_valid) @(negedge clk);
        chk(!busy, "R9", 320'(busy), 320'(0));
        chk(tag == exp_tag, "R9", 320'(tag), 320'(exp_tag));
        tag_seen = tag;
        @(negedge clk);
        chk(!tag_valid && tag == tag_seen, "R9", 320'(tag), 320'(tag_seen));
        chk(cap_n - cb == exp_n, "R4 R11", 320'(cap_n - cb), 320'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            chk(cap_in[cb+i] == exp_in[i], exp_lbl[i], cap_in[cb+i], exp_in[i]);
            chk(cap_r[cb+i] == exp_r[i], "R10", 320'(cap_r[cb+i]), 320'(exp_r[i]));
        end
        chk(ct_n - tb0 == n_pt, "R7", 320'(ct_n - tb0), 320'(n_pt));
        for (int i = 0; i < n_pt; i++) begin
            chk(ct_got[tb0+i] == exp_ct[i], (i == n_pt - 1) ? "R6 R7" : "R7",
                320'(ct_got[tb0+i]), 320'(exp_ct[i]));
            chk(int'(ctb_got[tb0+i]) == exp_ctb[i], "R7", 320'(ctb_got[tb0+i]), 320'(exp_ctb[i]));
        end
        if (n_ad == 0) chk(adr_seen == 0, "R5", 320'(adr_seen), 320'(0));
        if (noisy) chk(cap_r[cb] == ra, "R10", 320'(cap_r[cb]), 320'(ra));
        $display("case %s done", name);
    endtask

    task automatic t_reset();
        chk(!busy && !ad_ready && !pt_ready && !ct_valid && !tag_valid && !perm_start, "R1",
            320'({busy, ad_ready, pt_ready, ct_valid, tag_valid, perm_start}), 320'(0));
    endtask

    task automatic t_basic();
        key = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        nonce = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
        ra = 12; rb = 6;
        n_ad = 2; ad_ln = 3;
        ad_blk[0] = 64'h1111_2222_3333_4444; ad_blk[1] = 64'hABCD_EF01_2345_6789;
        n_pt = 3; pt_ln = 5;
        pt_blk[0] = 64'h0102_0304_0506_0708; pt_blk[1] = 64'hFFEE_DDCC_BBAA_9988;
        pt_blk[2] = 64'h7777_8888_9999_AAAA;
        run_case("basic", 0);
    endtask

    task automatic t_no_ad();
        key = 128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0;
        nonce = 128'h1357_9BDF_2468_ACE0_0F1E_2D3C_4B5A_6978;
        ra = 12; rb = 6;
        n_ad = 0; ad_ln = 8;
        n_pt = 1; pt_ln = 8;
        pt_blk[0] = 64'hCAFE_BABE_FEED_FACE;
        run_case("no_ad_full_block", 0);
    endtask

    task automatic t_rounds_empty();
        key = 128'h0F0F_F0F0_3C3C_C3C3_5555_AAAA_6969_9696;
        nonce = 128'h8000_0000_0000_0001_0000_0000_0000_0080;
        ra = 8; rb = 4;
        n_ad = 2; ad_ln = 0;
        ad_blk[0] = 64'h0123_4567_89AB_CDEF; ad_blk[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        n_pt = 1; pt_ln = 0;
        pt_blk[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        run_case("rounds_latch_empty_last", 1);
    endtask

    task automatic t_partial7();
        key = 128'hA5A5_5A5A_1111_EEEE_2222_DDDD_3333_CCCC;
        nonce = 128'h0;
        ra = 12; rb = 6;
        n_ad = 1; ad_ln = 7;
        ad_blk[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        n_pt = 2; pt_ln = 7;
        pt_blk[0] = 64'h0; pt_blk[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        run_case("partial7", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_ad();
        t_rounds_empty();
        t_partial7();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule